// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the write-side command interface of a parallel NOR flash device in a fully synchronous form. Every cycle in which `wr_en` is high is one bus write of an address and a data byte. The block recognises the multi-cycle unlock-and-command sequences and tracks the mode the device is in: array read, sequence in progress, identifier (autoselect) read, embedded program, embedded erase, erase suspended, and timeout fault. Program and erase run on internal busy counters whose lengths are parameters. A test input injects a timeout fault.

From that mode, a set of per-sector suspend flags and the sector of the current read, the block tells the read path whether a read returns array data or the status word. It also drives the status word. It has no memory array. The host addresses reads by sector index only.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Once reset is released, the block is in array-read mode (`mode_o`=0), `status_o` is 0x80 and `rd_status_o` is 0. No command is needed first.
- R2: The unlock is AA written where address bits [10:0] are 0x555, then 55 where bits [10:0] are 0x2AA. The command byte follows at 0x555. A0 waits for one program data write. 90 enters autoselect (`mode_o`=2). 80 enters erase setup. While a sequence is in progress, `mode_o`=1.
- R3: During a sequence, a write whose address or data is not the expected one returns the block to idle on the next cycle. A second AA in place of 55 counts as such a write. Idle is `mode_o`=0, or 5 if any sector is suspended.
- R4: Data F0 written to any address, in any mode, returns the block to idle on the next cycle. It keeps the suspend flags and clears a timeout fault.
- R5: The program data write starts a program. `mode_o`=3 for exactly PROG_CYCLES cycles, and then the block returns to idle by itself.
- R6: After erase setup, the writes AA@0x555 and 55@0x2AA are followed by one more write. 30 erases the sector that holds that write's address. 10 at 0x555 erases all sectors. `mode_o`=4 for ERASE_CYCLES cycles in total, not counting time spent suspended, and then the block returns to idle.
- R7: B0 written during an erase suspends it. `mode_o` becomes 5 and the erase targets become suspended. `rd_status_o` is 1 only for reads of a suspended sector. Writing 30 at idle while suspended resumes the erase and clears the flags.
- R8: A program may run while the erase is suspended, and afterwards the block returns to `mode_o`=5 with the same flags. An erase setup (80) issued while suspended is treated as a malformed sequence.
- R9: `force_timeout` high during a program or erase enters the fault mode (`mode_o`=6), which sets status bit 5. Only F0 leaves this mode. All other writes are ignored.
- R10: Autoselect mode ignores every write except F0.
- R11: The status word uses these bits: bit 7 is ready (not programming or erasing), bit 5 is timeout fault, bit 3 is erase active, bit 2 is some sector suspended, and all other bits are 0. `rd_status_o` is 1 during program, erase and fault.
- R12: During a program or erase, writes other than F0 and (during erase) B0 have no effect on the mode or the busy timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write in this cycle |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_sector | input | $clog2(NSECT) | Sector index of the current read |
| force_timeout | input | 1 | Test input: inject timeout fault |
| mode_o | output | 3 | 0 read, 1 sequence, 2 autoselect, 3 program, 4 erase, 5 suspended, 6 fault |
| status_o | output | 8 | Status word |
| rd_status_o | output | 1 | Read returns status instead of array data |

## Verification
The bench builds the block with AW=12, NSECT=8, PROG_CYCLES=4 and ERASE_CYCLES=12. With such short busy windows, random traffic regularly completes programs and erases. It also makes it possible to suspend an erase partway through, run a program inside the suspension and resume, all while counting the exact remaining erase cycles. Eight sectors of 512 words each place both unlock addresses in ordinary sectors, so sector erases and chip erases can both be told apart from the suspend flags.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_UL1, ST_UL2, ST_PDATA, ST_ESETUP, ST_EUL1, ST_EUL2,
    ST_AUTOSEL, ST_PBUSY, ST_EBUSY, ST_FAULT
  } fsm_st_t;

  typedef enum logic [2:0] {
    MODE_READ = 3'd0, MODE_SEQ = 3'd1, MODE_AUTO = 3'd2, MODE_PROG = 3'd3,
    MODE_ERASE = 3'd4, MODE_SUSP = 3'd5, MODE_FAULT = 3'd6
  } mode_t;

  localparam logic [7:0] CMD_KEY1   = 8'hAA;
  localparam logic [7:0] CMD_KEY2   = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_AUTO   = 8'h90;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam int         KEY_AW     = 11;
  localparam logic [KEY_AW-1:0] ADDR_K1 = 11'h555;
  localparam logic [KEY_AW-1:0] ADDR_K2 = 11'h2AA;
endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/fcd_busy_timer.sv
module fcd_busy_timer #(
  parameter int N = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic last
);
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)                   cnt_n = CW'(N - 1);
    else if (run && cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign last = (cnt_q == '0);

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(N - 1));
endmodule

// File: rtl/fcd_susp_map.sv
module fcd_susp_map #(
  parameter int NSECT = 8,
  localparam int SW = $clog2(NSECT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_start,
  input  logic          erase_chip,
  input  logic [SW-1:0] wr_sector,
  input  logic          susp_set,
  input  logic          susp_clr,
  input  logic [SW-1:0] rd_sector,
  output logic          any_susp,
  output logic          rd_hit
);
  logic [NSECT-1:0] tgt_q, tgt_n, flg_q, flg_n, dec;

  for (genvar g = 0; g < NSECT; g++) begin : g_dec
    assign dec[g] = erase_chip || (wr_sector == SW'(g));
  end

  always_comb begin
    tgt_n = tgt_q;
    flg_n = flg_q;
    if (erase_start) tgt_n = dec;
    if (susp_set)      flg_n = tgt_q;
    else if (susp_clr) flg_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      flg_q <= '0;
    end else begin
      tgt_q <= tgt_n;
      flg_q <= flg_n;
    end
  end

  assign any_susp = |flg_q;
  assign rd_hit   = flg_q[rd_sector];

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_set && flg_q == '0) |=> flg_q == '0);
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [KEY_AW-1:0] wr_key,
  input  logic [7:0]        wr_data,
  input  logic              force_timeout,
  input  logic              suspended,
  input  logic              prog_last,
  input  logic              erase_last,
  output fsm_st_t           state,
  output logic              prog_load,
  output logic              erase_load,
  output logic              erase_chip,
  output logic              susp_set,
  output logic              susp_clr
);
  fsm_st_t st_q, st_n;
  logic is_rst, k1, k2, at_k1;

  assign is_rst = wr_en && (wr_data == CMD_RESET);
  assign at_k1  = (wr_key == ADDR_K1);
  assign k1     = wr_en && (wr_data == CMD_KEY1) && at_k1;
  assign k2     = wr_en && (wr_data == CMD_KEY2) && (wr_key == ADDR_K2);

  always_comb begin
    st_n       = st_q;
    prog_load  = 1'b0;
    erase_load = 1'b0;
    erase_chip = 1'b0;
    susp_set   = 1'b0;
    susp_clr   = 1'b0;
    if (is_rst) begin
      st_n = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: if (wr_en) begin
          if (k1) st_n = ST_UL1;
          else if (wr_data == CMD_SECT && suspended) begin
            st_n     = ST_EBUSY;
            susp_clr = 1'b1;
          end
        end
        ST_UL1:    if (wr_en) st_n = k2 ? ST_UL2 : ST_IDLE;
        ST_UL2: if (wr_en) begin
          st_n = ST_IDLE;
          if (at_k1 && wr_data == CMD_PROG)                    st_n = ST_PDATA;
          else if (at_k1 && wr_data == CMD_AUTO)               st_n = ST_AUTOSEL;
          else if (at_k1 && wr_data == CMD_ESETUP && !suspended) st_n = ST_ESETUP;
        end
        ST_PDATA: if (wr_en) begin
          st_n      = ST_PBUSY;
          prog_load = 1'b1;
        end
        ST_ESETUP: if (wr_en) st_n = k1 ? ST_EUL1 : ST_IDLE;
        ST_EUL1:   if (wr_en) st_n = k2 ? ST_EUL2 : ST_IDLE;
        ST_EUL2: if (wr_en) begin
          st_n = ST_IDLE;
          if (wr_data == CMD_SECT) begin
            st_n       = ST_EBUSY;
            erase_load = 1'b1;
          end else if (wr_data == CMD_CHIP && at_k1) begin
            st_n       = ST_EBUSY;
            erase_load = 1'b1;
            erase_chip = 1'b1;
          end
        end
        ST_PBUSY: begin
          if (force_timeout)  st_n = ST_FAULT;
          else if (prog_last) st_n = ST_IDLE;
        end
        ST_EBUSY: begin
          if (force_timeout)   st_n = ST_FAULT;
          else if (erase_last) st_n = ST_IDLE;
          else if (wr_en && wr_data == CMD_SUSP) begin
            st_n     = ST_IDLE;
            susp_set = 1'b1;
          end
        end
        default: st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  assign state = st_q;

  assert_reset_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == CMD_RESET) |=> st_q == ST_IDLE);
  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAULT && !(wr_en && wr_data == CMD_RESET)) |=> st_q == ST_FAULT);
  assert_auto_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AUTOSEL && !(wr_en && wr_data == CMD_RESET)) |=> st_q == ST_AUTOSEL);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW           = 12,
  parameter int NSECT        = 8,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 64,
  localparam int SW = $clog2(NSECT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [SW-1:0] rd_sector,
  input  logic          force_timeout,
  output logic [2:0]    mode_o,
  output logic [7:0]    status_o,
  output logic          rd_status_o
);
  logic    rst_i_n;
  fsm_st_t state;
  logic    prog_load, erase_load, erase_chip, susp_set, susp_clr;
  logic    prog_last, erase_last, any_susp, rd_hit;
  logic    busy_p, busy_e, fault;
  mode_t   mode;

  fcd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  fcd_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_key(wr_addr[KEY_AW-1:0]),
    .wr_data(wr_data), .force_timeout(force_timeout), .suspended(any_susp),
    .prog_last(prog_last), .erase_last(erase_last), .state(state),
    .prog_load(prog_load), .erase_load(erase_load), .erase_chip(erase_chip),
    .susp_set(susp_set), .susp_clr(susp_clr)
  );

  fcd_busy_timer #(.N(PROG_CYCLES)) u_ptmr (
    .clk(clk), .rst_n(rst_i_n), .load(prog_load), .run(busy_p), .last(prog_last)
  );

  fcd_busy_timer #(.N(ERASE_CYCLES)) u_etmr (
    .clk(clk), .rst_n(rst_i_n), .load(erase_load), .run(busy_e), .last(erase_last)
  );

  fcd_susp_map #(.NSECT(NSECT)) u_susp (
    .clk(clk), .rst_n(rst_i_n), .erase_start(erase_load), .erase_chip(erase_chip),
    .wr_sector(wr_addr[AW-1 -: SW]), .susp_set(susp_set), .susp_clr(susp_clr),
    .rd_sector(rd_sector), .any_susp(any_susp), .rd_hit(rd_hit)
  );

  assign busy_p = (state == ST_PBUSY);
  assign busy_e = (state == ST_EBUSY);
  assign fault  = (state == ST_FAULT);

  always_comb begin
    case (state)
      ST_IDLE:    mode = any_susp ? MODE_SUSP : MODE_READ;
      ST_AUTOSEL: mode = MODE_AUTO;
      ST_PBUSY:   mode = MODE_PROG;
      ST_EBUSY:   mode = MODE_ERASE;
      ST_FAULT:   mode = MODE_FAULT;
      default:    mode = MODE_SEQ;
    endcase
  end

  assign mode_o      = mode;
  assign status_o    = {!(busy_p || busy_e), 1'b0, fault, 1'b0, busy_e, any_susp, 2'b00};
  assign rd_status_o = busy_p || busy_e || fault || rd_hit;

  assert_prog_ends_idle_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy_p && !force_timeout && prog_last) |=> (mode_o == MODE_READ || mode_o == MODE_SUSP));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int AW = 12, NSECT = 8, PC = 4, EC = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, ft;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] ra;
  logic [2:0] mode_o;
  logic [7:0] status_o;
  logic rd_status_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .NSECT(NSECT), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sector(ra), .force_timeout(ft), .mode_o(mode_o), .status_o(status_o),
    .rd_status_o(rd_status_o)
  );

  // reference model: 0 idle 1 ul1 2 ul2 3 pdata 4 esetup 5 eul1 6 eul2 7 auto 8 pbusy 9 ebusy 10 fault
  int m_st, m_pc, m_ec;
  logic [7:0] m_tgt, m_flg;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_mode();
    case (m_st)
      0: return (m_flg != 0) ? 5 : 0;
      7: return 2;
      8: return 3;
      9: return 4;
      10: return 6;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_stat();
    int s = 0;
    if (!(m_st == 8 || m_st == 9)) s |= 8'h80;
    if (m_st == 10) s |= 8'h20;
    if (m_st == 9) s |= 8'h08;
    if (m_flg != 0) s |= 8'h04;
    return s;
  endfunction

  task automatic mdl_step(bit we, logic [AW-1:0] a, logic [7:0] d, bit f);
    bit k1, k2, at, pl, el, ch, ss, sc;
    int ns;
    k1 = we && d == 8'hAA && a[10:0] == 11'h555;
    k2 = we && d == 8'h55 && a[10:0] == 11'h2AA;
    at = a[10:0] == 11'h555;
    pl = 0; el = 0; ch = 0; ss = 0; sc = 0; ns = m_st;
    if (we && d == 8'hF0) ns = 0;
    else case (m_st)
      0: if (we) begin
           if (k1) ns = 1;
           else if (d == 8'h30 && m_flg != 0) begin ns = 9; sc = 1; end
         end
      1: if (we) ns = k2 ? 2 : 0;
      2: if (we) begin
           ns = 0;
           if (at && d == 8'hA0) ns = 3;
           else if (at && d == 8'h90) ns = 7;
           else if (at && d == 8'h80 && m_flg == 0) ns = 4;
         end
      3: if (we) begin ns = 8; pl = 1; end
      4: if (we) ns = k1 ? 5 : 0;
      5: if (we) ns = k2 ? 6 : 0;
      6: if (we) begin
           ns = 0;
           if (d == 8'h30) begin ns = 9; el = 1; end
           else if (d == 8'h10 && at) begin ns = 9; el = 1; ch = 1; end
         end
      8: if (f) ns = 10; else if (m_pc == 0) ns = 0;
      9: if (f) ns = 10; else if (m_ec == 0) ns = 0;
         else if (we && d == 8'hB0) begin ns = 0; ss = 1; end
      default: ;
    endcase
    if (pl) m_pc = PC - 1; else if (m_st == 8 && m_pc > 0) m_pc--;
    if (el) m_ec = EC - 1; else if (m_st == 9 && m_ec > 0) m_ec--;
    if (ss) m_flg = m_tgt; else if (sc) m_flg = 0;
    if (el) m_tgt = ch ? 8'hFF : (8'h01 << a[11:9]);
    m_st = ns;
  endtask

  task automatic drive(bit we, logic [AW-1:0] a, logic [7:0] d, bit f);
    wr_en = we; wr_addr = a; wr_data = d; ft = f;
    mdl_step(we, a, d, f);
    @(negedge clk);
    wr_en = 0; ft = 0;
    chk("R3 mode vs model", int'(mode_o), exp_mode());
    chk("R11 status vs model", int'(status_o), exp_stat());
    chk("R7 read source vs model", int'(rd_status_o),
        int'(m_st == 8 || m_st == 9 || m_st == 10 || m_flg[ra]));
  endtask

  task automatic w(logic [AW-1:0] a, logic [7:0] d); drive(1, a, d, 0); endtask
  task automatic idle(); drive(0, '0, '0, 0); endtask
  task automatic unlock(); w(12'h555, 8'hAA); w(12'h2AA, 8'h55); endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; ft = 0; ra = '0;
    m_st = 0; m_pc = 0; m_ec = 0; m_tgt = 0; m_flg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 mode after reset", mode_o, 0);
    chk("R1 status after reset", status_o, 8'h80);
    chk("R1 read source after reset", rd_status_o, 0);
    // R2 / R5 program
    unlock();
    chk("R2 sequence mode", mode_o, 1);
    w(12'h555, 8'hA0);
    chk("R2 program armed", mode_o, 1);
    w(12'h0F3, 8'h3C);
    chk("R5 program busy", mode_o, 3);
    chk("R11 status while programming", status_o, 8'h00);
    chk("R11 read source while programming", rd_status_o, 1);
    repeat (PC - 1) idle();
    chk("R5 still busy at last cycle", mode_o, 3);
    idle();
    chk("R5 program done", mode_o, 0);
    // R3 aborts
    w(12'h555, 8'hAA); w(12'h2AB, 8'h55);
    chk("R3 wrong address", mode_o, 0);
    unlock(); w(12'h555, 8'h77);
    chk("R3 wrong command", mode_o, 0);
    w(12'h555, 8'hAA); w(12'h555, 8'hAA);
    chk("R3 out of order", mode_o, 0);
    // R10 autoselect
    unlock(); w(12'h555, 8'h90);
    chk("R2 autoselect", mode_o, 2);
    w(12'h555, 8'hAA); idle();
    chk("R10 autoselect ignores writes", mode_o, 2);
    w(12'h7FF, 8'hF0);
    chk("R4 reset leaves autoselect", mode_o, 0);
    unlock(); w(12'h123, 8'hF0);
    chk("R4 reset mid sequence", mode_o, 0);
    // R6 / R7 sector erase with suspend
    unlock(); w(12'h555, 8'h80); unlock(); w(12'h640, 8'h30);
    chk("R6 sector erase busy", mode_o, 4);
    chk("R11 status erasing", status_o, 8'h08);
    repeat (4) idle();
    w(12'h000, 8'hB0);
    chk("R7 suspended", mode_o, 5);
    chk("R11 status suspended", status_o, 8'h84);
    ra = 3'd3; idle();
    chk("R7 suspended sector reads status", rd_status_o, 1);
    ra = 3'd0; idle();
    chk("R7 other sector reads array", rd_status_o, 0);
    w(12'h000, 8'hF0);
    chk("R4 reset keeps suspension", mode_o, 5);
    // R8 program inside suspension
    unlock(); w(12'h555, 8'hA0); w(12'h010, 8'h5A);
    chk("R8 program in suspend", mode_o, 3);
    repeat (PC) idle();
    chk("R8 back to suspend", mode_o, 5);
    ra = 3'd3; idle();
    chk("R8 exception persists", rd_status_o, 1);
    ra = 3'd0;
    unlock(); w(12'h555, 8'h80);
    chk("R8 erase setup refused in suspend", mode_o, 5);
    // resume: EC-5 EBUSY cycles remain
    w(12'h200, 8'h30);
    chk("R7 resume", mode_o, 4);
    w(12'h555, 8'hAA);
    chk("R12 write ignored while erasing", mode_o, 4);
    repeat (EC - 7) idle();
    chk("R12 erase still busy", mode_o, 4);
    idle();
    chk("R6 erase done after remaining cycles", mode_o, 0);
    // chip erase
    unlock(); w(12'h555, 8'h80); unlock(); w(12'h555, 8'h10);
    chk("R6 chip erase busy", mode_o, 4);
    w(12'h000, 8'hB0);
    ra = 3'd7; idle();
    chk("R6 chip erase suspends top sector", rd_status_o, 1);
    ra = 3'd0; idle();
    chk("R6 chip erase suspends sector 0", rd_status_o, 1);
    w(12'h000, 8'h30);
    // R9 timeout fault
    drive(0, '0, '0, 1);
    chk("R9 fault mode", mode_o, 6);
    chk("R9 fault status", status_o, 8'hA0);
    unlock(); idle();
    chk("R9 fault ignores writes", mode_o, 6);
    w(12'h000, 8'hF0);
    chk("R9 reset clears fault", mode_o, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      bit we, f;
      a = AW'($urandom); we = 1; f = (($urandom % 50) == 0);
      ra = 3'($urandom);
      case ($urandom % 15)
        0, 1: begin a = 12'h555; d = 8'hAA; end
        2, 3: begin a = 12'h2AA; d = 8'h55; end
        4: begin a = 12'h555; d = 8'hA0; end
        5: begin a = 12'h555; d = 8'h80; end
        6: begin a = 12'h555; d = 8'h90; end
        7: d = 8'h30;
        8: begin a = 12'h555; d = 8'h10; end
        9: d = 8'hB0;
        10: d = 8'hF0;
        11: d = 8'($urandom);
        default: begin we = 0; d = 8'h00; end
      endcase
      drive(we, a, d, f);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule